// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block takes stereo audio arriving on a three-wire serial link (bit clock, left/right clock, data) and turns it into one 24-bit signed word per channel for the downstream filters. It accepts four framing families: right-justified, left-justified, I2S and DSP (short frame-sync pulse). Word lengths of 16, 20, 24 and 32 bits are supported, giving 13 distinct modes. The mode comes from a 3-bit format field in the mode register and an I2S select bit held in a separate framing register.

All three serial inputs pass through two-flop synchronisers into the system clock domain. Bit-clock rising edges are detected there, so the system clock must run at least four times faster than the bit clock. Completed words are normalised to 24 bits: short words are padded with zeros at the bottom, and the lowest 8 bits of 32-bit words are dropped. Each channel has a one-cycle valid strobe.

A powerdown bit forces both outputs to zero (mid-scale), discards all shift and framing state, and returns every setting to its default. After powerdown is released, or after reset, a fixed number of completed words (16 by default) are swallowed before output resumes. A de-emphasis enable bit is passed straight through to an output flag.

Top module: `aud_ser_rx`

## Requirements
- R1: A write with `cfgAddr`=0 loads the mode register: bit 0 powerdown, bit 1 de-emphasis, bits 4:2 format. A write with `cfgAddr`=1 loads the I2S select from bit 0. Format bits 1:0 select the word length (0=16, 1=20, 2=24, 3=32). The family is chosen by {I2S select, format bit 2}: 00 right-justified, 01 left-justified, 10 I2S, 11 DSP.
- R2: Left-justified: the MSB is the first bit sampled on a bit-clock rising edge after a left/right-clock change. Left/right clock high means the left channel.
- R3: I2S: the MSB is sampled one bit-clock later than in left-justified mode. Left/right clock low means the left channel.
- R4: Right-justified: the word is the last N bits sampled before a left/right-clock change, and it belongs to the channel of the half that just ended (high = left).
- R5: DSP: the left MSB is sampled on the bit-clock rising edge where the sync (left/right clock input) is first seen high. The N left bits are followed at once by the N right bits.
- R6: The output is the received word as 24-bit two's complement. 16- and 20-bit words are left-aligned with zero low bits. For 32-bit words the top 24 bits are kept.
- R7: Each completed word raises `leftValid` or `rightValid` for exactly one clock, never both at once. Output data changes only together with its strobe or when it is cleared.
- R8: Powerdown forces both data outputs to zero within two clocks of the write and clears de-emphasis, format and I2S select to 0. Writes to the framing register are ignored while powerdown is set.
- R9: After reset or powerdown release, the first 16 completed words produce no strobe. Later words are all delivered in order.
- R10: `deemphOn` follows the de-emphasis bit of the mode register.
- R11: A word length code of 3 outside DSP mode is decoded as 24 bits.
- R12: After reset both data outputs are zero, no strobe is raised and `deemphOn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bitClk | input | 1 | Serial bit clock (asynchronous) |
| lrClk | input | 1 | Left/right clock, or frame sync in DSP mode |
| serData | input | 1 | Serial audio data, MSB first |
| cfgWr | input | 1 | Register write strobe |
| cfgAddr | input | 1 | Register select: 0 mode, 1 framing |
| cfgData | input | 5 | Register write data |
| leftData | output | 24 | Last delivered left-channel word |
| leftValid | output | 1 | One-clock strobe for a new left word |
| rightData | output | 24 | Last delivered right-channel word |
| rightValid | output | 1 | One-clock strobe for a new right word |
| deemphOn | output | 1 | De-emphasis enable flag |

## Verification
The bench drives every framing family with 32-bit slots padded with ones. A receiver that took the wrong window would therefore pull padding into the word: for example, shifting an I2S word by one bit, or taking extra bits ahead of a right-justified word. Each run starts with powerdown and 16 junk words. A skip counter that is off by one, or that is not rearmed, would then let a junk word reach the scoreboard ahead of the expected data. One right-justified run follows a DSP run without rewriting the I2S select, and pokes that select during powerdown. Failing to clear it, or honouring the poke, would decode the wrong family. Runs at 32 bits, at the "32-bit" code outside DSP, and at 16 bits check that the wrong bits are not kept or zeroed.

// File: rtl/aud_ser_rx_pkg.sv
package aud_ser_rx_pkg;
  localparam int SLOT_W = 32;
  localparam int OUT_W  = 24;

  typedef enum logic [1:0] {LEN16 = 2'd0, LEN20 = 2'd1, LEN24 = 2'd2, LEN32 = 2'd3} wordLen_e;
  typedef enum logic [1:0] {FAM_RJ = 2'd0, FAM_LJ = 2'd1, FAM_I2S = 2'd2, FAM_DSP = 2'd3} family_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic     shift;
    logic     sdBit;
    logic     capL;
    logic     capR;
    logic     fromOld;
    logic     clear;
    wordLen_e wlen;
  } rxStrobe_t;

  function automatic int lenBits(wordLen_e len);
    case (len)
      LEN16:   return 16;
      LEN20:   return 20;
      LEN24:   return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [OUT_W-1:0] normalise(input logic [SLOT_W-1:0] raw, input wordLen_e len);
    case (len)
      LEN16:   return {raw[15:0], 8'h00};
      LEN20:   return {raw[19:0], 4'h0};
      LEN24:   return raw[23:0];
      default: return raw[31:8];
    endcase
  endfunction
endpackage

// File: rtl/aud_ser_rx_ctrl.sv
module aud_ser_rx_ctrl
  import aud_ser_rx_pkg::*;
#(
  parameter int SKIP_COUNT = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bitClk,
  input  logic      lrClk,
  input  logic      serData,
  input  logic      cfgWr,
  input  logic      cfgAddr,
  input  logic [4:0] cfgData,
  output logic      deemphOn,
  output rxStrobe_t strobe
);
  localparam int CNT_W  = $clog2(2 * SLOT_W + 1);
  localparam int SKIP_W = $clog2(SKIP_COUNT + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [SKIP_W-1:0] SKIP_LOAD = SKIP_W'(SKIP_COUNT);

  logic       pdOn, deemphReg, i2sSel;
  logic [2:0] fmtSel;

  // configuration registers; powerdown returns settings to defaults
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdOn <= 1'b0; deemphReg <= 1'b0; i2sSel <= 1'b0; fmtSel <= '0;
    end else if (cfgWr) begin
      if (!cfgAddr) begin
        if (cfgData[0]) begin
          pdOn <= 1'b1; deemphReg <= 1'b0; fmtSel <= '0; i2sSel <= 1'b0;
        end else begin
          pdOn <= 1'b0; deemphReg <= cfgData[1]; fmtSel <= cfgData[4:2];
        end
      end else if (!pdOn) begin
        i2sSel <= cfgData[0];
      end
    end
  end
  assign deemphOn = deemphReg;

  // two-flop synchronisers and bit-clock edge detect
  logic [1:0] bclkSync, lrSync, sdSync;
  logic       bclkPrev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclkSync <= '0; lrSync <= '0; sdSync <= '0; bclkPrev <= 1'b0;
    end else begin
      bclkSync <= {bclkSync[0], bitClk};
      lrSync   <= {lrSync[0], lrClk};
      sdSync   <= {sdSync[0], serData};
      bclkPrev <= bclkSync[1];
    end
  end

  logic rise, lrNow;
  assign rise  = bclkSync[1] & ~bclkPrev;
  assign lrNow = lrSync[1];

  // format decode
  family_e    fam;
  wordLen_e   wlen;
  logic [CNT_W-1:0] nBits;
  always_comb begin
    case ({i2sSel, fmtSel[2]})
      2'b00:   fam = FAM_RJ;
      2'b01:   fam = FAM_LJ;
      2'b10:   fam = FAM_I2S;
      default: fam = FAM_DSP;
    endcase
    wlen = wordLen_e'(fmtSel[1:0]);
    if (fam != FAM_DSP && wlen == LEN32) wlen = LEN24;
    nBits = CNT_W'(lenBits(wlen));
  end

  // framing state
  logic             primed, halfActive, lrLast;
  logic [CNT_W-1:0] cnt;
  logic [SKIP_W-1:0] skipCnt;

  logic             boundary, active, wordL, wordR, fromOld, done, keep;
  logic [CNT_W-1:0] idx;
  always_comb begin
    boundary = primed && ((fam == FAM_DSP) ? (lrNow && !lrLast) : (lrNow != lrLast));
    idx      = boundary ? '0 : cnt;
    active   = boundary || halfActive;
    wordL    = 1'b0;
    wordR    = 1'b0;
    fromOld  = 1'b0;
    case (fam)
      FAM_RJ: if (boundary && halfActive) begin
        fromOld = 1'b1;
        if (lrLast) wordL = 1'b1; else wordR = 1'b1;
      end
      FAM_LJ: if (active && idx == nBits - 1'b1) begin
        if (lrNow) wordL = 1'b1; else wordR = 1'b1;
      end
      FAM_I2S: if (active && idx == nBits) begin
        if (!lrNow) wordL = 1'b1; else wordR = 1'b1;
      end
      default: begin
        if (active && idx == nBits - 1'b1) wordL = 1'b1;
        else if (active && idx == (nBits << 1) - 1'b1) wordR = 1'b1;
      end
    endcase
    done = rise && !pdOn && (wordL || wordR);
    keep = done && (skipCnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0; halfActive <= 1'b0; lrLast <= 1'b0; cnt <= '0; skipCnt <= SKIP_LOAD;
    end else if (pdOn) begin
      primed <= 1'b0; halfActive <= 1'b0; lrLast <= 1'b0; cnt <= '0; skipCnt <= SKIP_LOAD;
    end else if (rise) begin
      primed <= 1'b1;
      lrLast <= lrNow;
      if (boundary) halfActive <= 1'b1;
      cnt <= (idx == CNT_MAX) ? idx : idx + 1'b1;
      if (done && skipCnt != '0) skipCnt <= skipCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.shift   = rise && !pdOn;
    strobe.sdBit   = sdSync[1];
    strobe.capL    = keep && wordL;
    strobe.capR    = keep && wordR;
    strobe.fromOld = fromOld;
    strobe.clear   = pdOn;
    strobe.wlen    = wlen;
  end
endmodule

// File: rtl/aud_ser_rx_dpath.sv
module aud_ser_rx_dpath
  import aud_ser_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  rxStrobe_t        strobe,
  output logic [OUT_W-1:0] leftData,
  output logic             leftValid,
  output logic [OUT_W-1:0] rightData,
  output logic             rightValid
);
  logic [SLOT_W-1:0] shReg, shNext, picked;
  logic [OUT_W-1:0]  normWord;

  always_comb begin
    shNext   = {shReg[SLOT_W-2:0], strobe.sdBit};
    picked   = strobe.fromOld ? shReg : shNext;
    normWord = normalise(picked, strobe.wlen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shReg <= '0; leftData <= '0; rightData <= '0; leftValid <= 1'b0; rightValid <= 1'b0;
    end else if (strobe.clear) begin
      shReg <= '0; leftData <= '0; rightData <= '0; leftValid <= 1'b0; rightValid <= 1'b0;
    end else begin
      leftValid  <= strobe.capL;
      rightValid <= strobe.capR;
      if (strobe.shift) shReg <= shNext;
      if (strobe.capL) leftData <= normWord;
      if (strobe.capR) rightData <= normWord;
    end
  end
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
  import aud_ser_rx_pkg::*;
#(
  parameter int SKIP_COUNT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bitClk,
  input  logic        lrClk,
  input  logic        serData,
  input  logic        cfgWr,
  input  logic        cfgAddr,
  input  logic [4:0]  cfgData,
  output logic [23:0] leftData,
  output logic        leftValid,
  output logic [23:0] rightData,
  output logic        rightValid,
  output logic        deemphOn
);
  rxStrobe_t strobe;

  aud_ser_rx_ctrl #(.SKIP_COUNT(SKIP_COUNT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bitClk(bitClk), .lrClk(lrClk), .serData(serData),
    .cfgWr(cfgWr), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .deemphOn(deemphOn), .strobe(strobe)
  );

  aud_ser_rx_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .leftData(leftData), .leftValid(leftValid),
    .rightData(rightData), .rightValid(rightValid)
  );
endmodule

// File: rtl/aud_ser_rx_chk.sv
module aud_ser_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfgWr,
  input logic        cfgAddr,
  input logic [4:0]  cfgData,
  input logic [23:0] leftData,
  input logic        leftValid,
  input logic [23:0] rightData,
  input logic        rightValid,
  input logic        deemphOn
);
  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(leftValid && rightValid));
  // R7
  left_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leftValid |=> !leftValid);
  // R7
  right_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rightValid |=> !rightValid);
  // R7
  left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(leftData) |-> (leftValid || leftData == 24'd0));
  // R7
  right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rightData) |-> (rightValid || rightData == 24'd0));
  // R8
  pd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWr && !cfgAddr && cfgData[0]) |=> ##1 (leftData == 24'd0 && rightData == 24'd0 && !deemphOn));
  // R10
  deemph_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgWr |=> $stable(deemphOn));
endmodule

bind aud_ser_rx aud_ser_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfgWr(cfgWr), .cfgAddr(cfgAddr), .cfgData(cfgData),
  .leftData(leftData), .leftValid(leftValid), .rightData(rightData),
  .rightValid(rightValid), .deemphOn(deemphOn)
);

// File: tb/aud_ser_rx_tb.sv
module aud_ser_rx_tb;
  import aud_ser_rx_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bitClk = 1'b0, lrClk = 1'b0, serData = 1'b0;
  logic cfgWr = 1'b0, cfgAddr = 1'b0;
  logic [4:0] cfgData = '0;
  logic [23:0] leftData, rightData;
  logic leftValid, rightValid, deemphOn;

  always #2 clk = ~clk;

  aud_ser_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bitClk(bitClk), .lrClk(lrClk), .serData(serData),
    .cfgWr(cfgWr), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .leftData(leftData), .leftValid(leftValid), .rightData(rightData),
    .rightValid(rightValid), .deemphOn(deemphOn)
  );

  typedef struct packed { logic isRight; logic [23:0] data; } item_t;
  item_t expQ[$];
  int checks = 0, fails = 0;
  bit finished = 0;
  string curReq = "R12";

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] expWord(logic [31:0] raw, int n);
    logic [31:0] v;
    if (n == 32) return raw[31:8];
    v = raw & ((32'h1 << n) - 1);
    return 24'(v) << (24 - n);
  endfunction

  // monitor: pops expected words as strobes appear
  logic prevL = 1'b0, prevR = 1'b0;
  task automatic popCompare(logic isRight, logic [23:0] data, logic prev);
    check(!prev, "R7", "strobe longer than one clock", 1, 0);
    if (expQ.size() == 0) check(0, "R9", "unexpected word", {isRight, data}, 0);
    else begin
      item_t e = expQ.pop_front();
      check(e.isRight == isRight && e.data == data, curReq, "word", {isRight, data}, {e.isRight, e.data});
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (leftValid && rightValid) check(0, "R7", "both strobes", 1, 0);
      if (leftValid) popCompare(1'b0, leftData, prevL);
      if (rightValid) popCompare(1'b1, rightData, prevR);
    end
    prevL <= leftValid;
    prevR <= rightValid;
  end

  task automatic cfgWrite(logic a, logic [4:0] d);
    @(negedge clk);
    cfgWr = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic bitOut(logic d, logic lr);
    serData = d; lrClk = lr;
    #16 bitClk = 1'b1;
    #16 bitClk = 1'b0;
  endtask

  task automatic sendFrames(family_e fam, int n, int count, bit push);
    for (int f = 0; f < count; f++) begin
      logic [31:0] lv, rv;
      lv = $urandom; rv = $urandom;
      if (push) begin
        expQ.push_back('{isRight: 1'b0, data: expWord(lv, n)});
        expQ.push_back('{isRight: 1'b1, data: expWord(rv, n)});
      end
      case (fam)
        FAM_LJ: begin
          for (int i = 0; i < 32; i++) bitOut(i < n ? lv[n-1-i] : 1'b1, 1'b1);
          for (int i = 0; i < 32; i++) bitOut(i < n ? rv[n-1-i] : 1'b1, 1'b0);
        end
        FAM_I2S: begin
          for (int i = 0; i < 32; i++) bitOut((i >= 1 && i <= n) ? lv[n-i] : 1'b1, 1'b0);
          for (int i = 0; i < 32; i++) bitOut((i >= 1 && i <= n) ? rv[n-i] : 1'b1, 1'b1);
        end
        FAM_RJ: begin
          for (int i = 0; i < 32; i++) bitOut(i >= 32 - n ? lv[31-i] : 1'b1, 1'b1);
          for (int i = 0; i < 32; i++) bitOut(i >= 32 - n ? rv[31-i] : 1'b1, 1'b0);
        end
        default: begin
          for (int i = 0; i < 2 * n; i++) bitOut(i < n ? lv[n-1-i] : rv[2*n-1-i], i == 0);
          for (int i = 0; i < 8; i++) bitOut(1'b1, 1'b0);
        end
      endcase
    end
  endtask

  task automatic runTest(logic i2s, logic [2:0] fmt, logic deemph, int n, family_e fam,
                         string req, bit pokeI2s);
    cfgWrite(1'b0, 5'b00001);
    repeat (4) @(negedge clk);
    check(leftData == 0 && rightData == 0, "R8", "outputs in powerdown", {leftData, rightData}, 0);
    check(deemphOn == 1'b0, "R8", "deemphasis cleared by powerdown", deemphOn, 0);
    if (pokeI2s) cfgWrite(1'b1, 5'b00001);   // R8: ignored while powered down
    cfgWrite(1'b0, {fmt, deemph, 1'b0});
    if (i2s) cfgWrite(1'b1, 5'b00001);
    repeat (2) @(negedge clk);
    check(deemphOn == deemph, "R10", "deemphasis flag", deemphOn, deemph);
    curReq = req;
    repeat (4) bitOut(1'b1, fam == FAM_I2S);
    sendFrames(fam, n, 8, 1'b0);             // R9: these 16 words are swallowed
    sendFrames(fam, n, 3, 1'b1);
    repeat (4) bitOut(1'b0, fam == FAM_LJ || fam == FAM_RJ);
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R9", "words still pending", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R12 reset state
    check(leftData == 0 && rightData == 0, "R12", "data after reset", {leftData, rightData}, 0);
    check(!leftValid && !rightValid, "R12", "strobes after reset", {leftValid, rightValid}, 0);
    check(deemphOn == 1'b0, "R12", "deemphasis after reset", deemphOn, 0);

    runTest(1'b0, 3'b110, 1'b1, 24, FAM_LJ,  "R1/R2/R6",  1'b0);
    runTest(1'b1, 3'b000, 1'b0, 16, FAM_I2S, "R1/R3/R6",  1'b0);
    runTest(1'b1, 3'b111, 1'b1, 32, FAM_DSP, "R1/R5/R6",  1'b0);
    runTest(1'b0, 3'b001, 1'b0, 20, FAM_RJ,  "R4/R8",     1'b1);
    runTest(1'b0, 3'b111, 1'b0, 24, FAM_LJ,  "R11",       1'b0);
    runTest(1'b1, 3'b100, 1'b0, 16, FAM_DSP, "R5/R6",     1'b0);
    runTest(1'b0, 3'b000, 1'b1, 16, FAM_RJ,  "R4/R6",     1'b0);
    runTest(1'b1, 3'b001, 1'b0, 20, FAM_I2S, "R3/R6",     1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule